// File: doc/BRIEF.md
# SPI Master Word Shifter

This block moves one SPI word at a time as bus master. A word is taken from a small transmit queue and shifted out on MOSI. At the same time a word is gathered from MISO, or from MOSI itself when loopback is on, and placed into a small receive queue. The clock rate is set outside the block. An external divider supplies `sck_tick_i`, and each tick moves the serial clock by one half period. Word length, bit order, clock polarity, clock phase and loopback are static inputs. They may change only while no word is in flight.

Words are not right-justified in the 32-bit data registers. Their placement depends on the bit order. An event vector gives two live queue indications, transmit-not-full and receive-not-empty. It also gives two sticky error flags, overrun and underrun, which software clears by writing ones. Slave selects are active low and one bit per slave. A registered copy of the select register drives them.

Top module: `spi_master_engine`

## Requirements
- R1: A word is `len_i`+1 bits long for `len_i` 3..15 (4 to 16 bits). With `word32_i` set it is 32 bits whatever `len_i` holds. Each word gives exactly that many SCK pulses.
- R2: MSB first (`msb_first_i`=1), short words: transmit bits are taken from bit 31 downward. The received value is stored with its LSB at bit 16.
- R3: LSB first (`msb_first_i`=0), short words: transmit bits are taken from bit 0 upward. The received value is stored with its top bit at bit 15.
- R4: 32-bit words are sent and stored unshifted, in either bit order.
- R5: SCK rests at `cpol_i`. With `cpha_i`=0, MISO is sampled on each leading edge and MOSI changes on trailing edges. With `cpha_i`=1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R6: With `loop_i`=1, the received bits are the MOSI bits and `miso_i` has no effect.
- R7: `evt_o` bit 8 is 1 while the transmit queue has room. `evt_o` bit 9 is 1 while the receive queue holds a word. No other bits of `evt_o` are used except bits 11 and 12.
- R8: If a word completes while the receive queue is full, `evt_o` bit 12 (overrun) is set and the word is dropped.
- R9: A read of an empty receive queue sets `evt_o` bit 11 (underrun). A 1 in bit 11 or bit 12 of `evt_clr_i` clears that flag. Zeros in `evt_clr_i` leave the flag unchanged.
- R10: Words written while `en_i`=0 are discarded. No transfer results from them, even after `en_i` is raised.
- R11: `ss_no` follows `ssel_i` one cycle later. After reset it is all ones, which means no slave is selected.
- R12: After reset, SCK is at `cpol_i`, both queues are empty and `evt_o` equals 0x0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Core enable; gates transmit writes and the start of words |
| loop_i | input | 1 | Internal loopback of MOSI into the receiver |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | Clock phase |
| msb_first_i | input | 1 | 1 = MSB first, 0 = LSB first |
| len_i | input | 4 | Word length minus one (3..15) |
| word32_i | input | 1 | Selects 32-bit words |
| sck_tick_i | input | 1 | Half-period enable from the divider |
| tx_wr_i | input | 1 | Push `tx_data_i` into the transmit queue |
| tx_data_i | input | 32 | Transmit word, aligned per R2/R3/R4 |
| rx_rd_i | input | 1 | Pop the receive queue |
| rx_data_o | output | 32 | Head of the receive queue |
| evt_clr_i | input | 16 | Write-one-to-clear strobes for the sticky flags |
| evt_o | output | 16 | Event vector |
| ssel_i | input | N_SLAVES | Slave select register, active low |
| ss_no | output | N_SLAVES | Slave select outputs, active low |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench builds the block with queue depth 2 and four slave selects. At depth 2, three back-to-back writes fill the transmit queue and overrun the receive queue, so R7 and R8 are easy to reach. The sweep covers every word length, both bit orders, all four clock modes and loopback on and off. For each word the bench computes the aligned transmit and receive values itself. A bench slave drives MISO on the launch edges and collects MOSI on the sample edges. Both tick rates are used, one tick per cycle and one tick per three cycles.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = $clog2(WORD_W + 1);
  localparam int EDGE_W = $clog2(2 * WORD_W);
  localparam int EVT_W  = 16;
  localparam int EVT_NF = 8;
  localparam int EVT_NE = 9;
  localparam int EVT_UN = 11;
  localparam int EVT_OV = 12;

  typedef struct packed {
    logic             cpol;
    logic             cpha;
    logic             msb;
    logic             loop;
    logic [LEN_W-1:0] nbits;
  } xfer_cfg_t;
endpackage

// File: rtl/spi_eng_fifo.sv
module spi_eng_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign data_o  = mem[rd_q];

  always_ff @(posedge clk_i) if (do_push) mem[wr_q] <= data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  assert_fifo_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter
  import spi_eng_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  xfer_cfg_t         cfg_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_word_o
);
  logic              busy_q, sck_q;
  logic [EDGE_W-1:0] edge_q;
  logic [WORD_W-1:0] tx_sh_q, rx_sh_q, rx_nxt;
  logic [EDGE_W:0]   last_idx;
  logic              last_edge, sample_edge, launch_edge, miso_eff;

  always_comb begin
    last_idx    = {cfg_i.nbits[EDGE_W-1:0], 1'b0} - 1'b1;
    last_edge   = ({1'b0, edge_q} == last_idx);
    // cpha=0 samples on even (leading) edges, cpha=1 on odd (trailing)
    sample_edge = cfg_i.cpha ? edge_q[0] : ~edge_q[0];
    launch_edge = cfg_i.cpha ? (~edge_q[0] & (edge_q != '0)) : edge_q[0];
    mosi_o      = cfg_i.msb ? tx_sh_q[WORD_W-1] : tx_sh_q[0];
    miso_eff    = cfg_i.loop ? mosi_o : miso_i;
    rx_nxt      = rx_sh_q;
    if (sample_edge)
      rx_nxt = cfg_i.msb ? {rx_sh_q[WORD_W-2:0], miso_eff} : {miso_eff, rx_sh_q[WORD_W-1:1]};
    if (cfg_i.nbits == LEN_W'(WORD_W)) rx_word_o = rx_nxt;
    else if (cfg_i.msb)                rx_word_o = rx_nxt << (WORD_W / 2);
    else                               rx_word_o = rx_nxt >> (WORD_W / 2);
  end

  assign sck_o  = sck_q ^ cfg_i.cpol;
  assign busy_o = busy_q;
  assign done_o = busy_q & tick_i & last_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
      edge_q  <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        edge_q  <= '0;
        tx_sh_q <= word_i;
        rx_sh_q <= '0;
      end
    end else if (tick_i) begin
      sck_q   <= ~sck_q;
      rx_sh_q <= rx_nxt;
      if (launch_edge) tx_sh_q <= cfg_i.msb ? (tx_sh_q << 1) : (tx_sh_q >> 1);
      if (last_edge) busy_q <= 1'b0;
      else           edge_q <= edge_q + 1'b1;
    end
  end

  assert_sck_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sck_o == cfg_i.cpol));
  assert_edge_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> ({1'b0, edge_q} <= last_idx));
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_eng_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int N_SLAVES   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                loop_i,
  input  logic                cpol_i,
  input  logic                cpha_i,
  input  logic                msb_first_i,
  input  logic [3:0]          len_i,
  input  logic                word32_i,
  input  logic                sck_tick_i,
  input  logic                tx_wr_i,
  input  logic [31:0]         tx_data_i,
  input  logic                rx_rd_i,
  output logic [31:0]         rx_data_o,
  input  logic [15:0]         evt_clr_i,
  output logic [15:0]         evt_o,
  input  logic [N_SLAVES-1:0] ssel_i,
  output logic [N_SLAVES-1:0] ss_no,
  output logic                sck_o,
  output logic                mosi_o,
  input  logic                miso_i
);
  xfer_cfg_t         cfg;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              busy, done, start;
  logic [WORD_W-1:0] tx_head, rx_word;
  logic              ov_q, un_q;
  logic [N_SLAVES-1:0] ss_q;

  always_comb begin
    cfg.cpol  = cpol_i;
    cfg.cpha  = cpha_i;
    cfg.msb   = msb_first_i;
    cfg.loop  = loop_i;
    cfg.nbits = word32_i ? LEN_W'(WORD_W) : LEN_W'(len_i) + 1'b1;
  end

  assign start = en_i & ~tx_empty & ~busy;

  spi_eng_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_q (
    .clk_i, .rst_ni, .push_i(tx_wr_i & en_i), .data_i(tx_data_i),
    .pop_i(start), .data_o(tx_head), .full_o(tx_full), .empty_o(tx_empty));

  spi_eng_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_q (
    .clk_i, .rst_ni, .push_i(done & ~rx_full), .data_i(rx_word),
    .pop_i(rx_rd_i), .data_o(rx_data_o), .full_o(rx_full), .empty_o(rx_empty));

  spi_eng_shifter u_shift (
    .clk_i, .rst_ni, .cfg_i(cfg), .start_i(start), .word_i(tx_head),
    .tick_i(sck_tick_i), .miso_i, .sck_o, .mosi_o, .busy_o(busy),
    .done_o(done), .rx_word_o(rx_word));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_q <= 1'b0;
      un_q <= 1'b0;
      ss_q <= '1;
    end else begin
      ss_q <= ssel_i;
      if (done & rx_full)          ov_q <= 1'b1;
      else if (evt_clr_i[EVT_OV])  ov_q <= 1'b0;
      if (rx_rd_i & rx_empty)      un_q <= 1'b1;
      else if (evt_clr_i[EVT_UN])  un_q <= 1'b0;
    end
  end

  assign ss_no = ss_q;

  always_comb begin
    evt_o         = '0;
    evt_o[EVT_NF] = ~tx_full;
    evt_o[EVT_NE] = ~rx_empty;
    evt_o[EVT_UN] = un_q;
    evt_o[EVT_OV] = ov_q;
  end

  assert_overrun_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && rx_full) |=> evt_o[EVT_OV]);
  assert_underrun_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && rx_empty) |=> evt_o[EVT_UN]);
  assert_tx_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(tx_empty) && $stable(tx_full)));
endmodule

// File: tb/spi_master_engine_test.sv
`timescale 1ns/1ps
module spi_master_engine_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_ni = 1'b0, en_i = 1'b0, loop_i = 1'b0, cpol_i = 1'b0, cpha_i = 1'b0;
  logic        msb_first_i = 1'b1, word32_i = 1'b0, tx_wr_i = 1'b0, rx_rd_i = 1'b0, miso_i = 1'b0;
  logic [3:0]  len_i = 4'd7;
  logic [31:0] tx_data_i = '0, rx_data_o;
  logic [15:0] evt_clr_i = '0, evt_o;
  logic [3:0]  ssel_i = 4'hF, ss_no;
  logic        sck_o, mosi_o, sck_tick;

  int n_chk = 0, n_fail = 0;
  int div = 1, div_cnt = 0;
  logic tick_en = 1'b0;

  always @(negedge clk) div_cnt <= (div_cnt >= div - 1) ? 0 : div_cnt + 1;
  assign sck_tick = tick_en && (div_cnt == 0);

  spi_master_engine #(.FIFO_DEPTH(2), .N_SLAVES(4)) uut (
    .clk_i(clk), .rst_ni, .en_i, .loop_i, .cpol_i, .cpha_i, .msb_first_i, .len_i,
    .word32_i, .sck_tick_i(sck_tick), .tx_wr_i, .tx_data_i, .rx_rd_i, .rx_data_o,
    .evt_clr_i, .evt_o, .ssel_i, .ss_no, .sck_o, .mosi_o, .miso_i);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pop_rx();
    @(negedge clk) rx_rd_i = 1'b1;
    @(negedge clk) rx_rd_i = 1'b0;
  endtask

  task automatic run_xfer(input int c, input int ph, input int m, input int lf,
                          input int w32, input int lp, input int seed);
    int n, k, pulses;
    bit got, lead, smp;
    logic prev;
    logic [31:0] mask, v, p, txw, src, expv, cap;
    string tag;
    n    = w32 ? 32 : lf + 1;
    mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
    v    = (seed * 32'h9E37_79B1 + 32'h0123_4567) & mask;
    p    = ((seed * 32'h85EB_CA6B) ^ 32'hC2B2_AE35) & mask;
    txw  = (n == 32 || m == 0) ? v : v << (32 - n);
    src  = lp ? v : p;
    expv = (n == 32) ? src : (m ? src << 16 : src << (16 - n));
    tag  = lp ? "R6" : (w32 ? "R4" : (m ? "R2" : "R3"));
    @(negedge clk);
    cpol_i = c[0]; cpha_i = ph[0]; msb_first_i = m[0]; len_i = lf[3:0];
    word32_i = w32[0]; loop_i = lp[0]; en_i = 1'b1; tick_en = 1'b1;
    div = seed[0] ? 3 : 1;
    k = 0; pulses = 0; cap = '0; got = 0;
    miso_i = m ? p[n-1] : p[0];
    tx_data_i = txw; tx_wr_i = 1'b1;
    @(negedge clk) tx_wr_i = 1'b0;
    prev = sck_o;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (sck_o !== prev) begin
        lead = (sck_o != c[0]);
        if (lead) pulses++;
        smp = ph ? !lead : lead;
        if (smp) begin
          if (m) cap = {cap[30:0], mosi_o};
          else   cap[k] = mosi_o;
          k++;
          if (k < n) miso_i = m ? p[n-1-k] : p[k];
        end
      end
      prev = sck_o;
      if (evt_o[9]) got = 1;
    end
    check(got, "R1 word completes", 32'(got), 32'd1);
    check(pulses == n, "R1 sck pulse count", 32'(pulses), 32'(n));
    check(cap == v, {tag, " R5 mosi bits"}, cap, v);
    check(rx_data_o == expv, {tag, " rx alignment"}, rx_data_o, expv);
    check(sck_o == c[0], "R5 sck idle level", 32'(sck_o), 32'(c));
    pop_rx();
    check(evt_o[9] == 1'b0, "R7 not-empty after pop", 32'(evt_o[9]), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int toggles, seed;
    logic prev;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(evt_o == 16'h0100, "R12 evt after reset", 32'(evt_o), 32'h0100);
    check(ss_no == 4'hF, "R11 ss after reset", 32'(ss_no), 32'hF);
    check(sck_o == 1'b0, "R12 sck after reset", 32'(sck_o), 32'd0);

    // R11 select follows register one cycle later
    ssel_i = 4'b1101;
    @(negedge clk);
    check(ss_no == 4'b1101, "R11 ss follows ssel", 32'(ss_no), 32'hD);
    ssel_i = 4'hF;

    // R10 writes while disabled are dropped
    tick_en = 1'b1; div = 1; en_i = 1'b0;
    tx_data_i = 32'hDEAD_BEEF; tx_wr_i = 1'b1;
    @(negedge clk) tx_wr_i = 1'b0;
    toggles = 0; prev = sck_o;
    repeat (40) begin @(negedge clk); if (sck_o !== prev) toggles++; prev = sck_o; end
    check(toggles == 0, "R10 no sck while disabled", 32'(toggles), 32'd0);
    en_i = 1'b1;
    repeat (40) begin @(negedge clk); if (sck_o !== prev) toggles++; prev = sck_o; end
    check(toggles == 0, "R10 no sck after enable", 32'(toggles), 32'd0);
    check(evt_o == 16'h0100, "R10 queues stay empty", 32'(evt_o), 32'h0100);

    // R7/R8 fill tx queue, overrun rx queue (depth 2)
    tick_en = 1'b0; loop_i = 1'b1; msb_first_i = 1'b1; len_i = 4'd7; word32_i = 1'b0;
    cpol_i = 1'b0; cpha_i = 1'b0;
    tx_wr_i = 1'b1; tx_data_i = 32'hA500_0000;
    @(negedge clk) tx_data_i = 32'h3C00_0000;
    @(negedge clk) tx_data_i = 32'h0F00_0000;
    @(negedge clk) tx_wr_i = 1'b0;
    check(evt_o[8] == 1'b0, "R7 not-full clears when full", 32'(evt_o[8]), 32'd0);
    tick_en = 1'b1;
    repeat (200) @(negedge clk);
    check(evt_o == 16'h1300, "R8 overrun flagged", 32'(evt_o), 32'h1300);
    check(rx_data_o == 32'h00A5_0000, "R8 first word kept", rx_data_o, 32'h00A5_0000);
    pop_rx();
    check(rx_data_o == 32'h003C_0000, "R8 second word kept", rx_data_o, 32'h003C_0000);
    pop_rx();
    check(evt_o[9] == 1'b0, "R8 third word dropped", 32'(evt_o[9]), 32'd0);

    // R9 write-one-to-clear and underrun
    evt_clr_i = 16'hEFFF;
    @(negedge clk) evt_clr_i = '0;
    check(evt_o[12] == 1'b1, "R9 other clear bits ignored", 32'(evt_o[12]), 32'd1);
    evt_clr_i = 16'h1000;
    @(negedge clk) evt_clr_i = '0;
    check(evt_o[12] == 1'b0, "R9 overrun cleared", 32'(evt_o[12]), 32'd0);
    pop_rx();
    check(evt_o[11] == 1'b1, "R9 underrun set", 32'(evt_o[11]), 32'd1);
    evt_clr_i = 16'h0800;
    @(negedge clk) evt_clr_i = '0;
    check(evt_o == 16'h0100, "R9 underrun cleared", 32'(evt_o), 32'h0100);

    // Sweep: loopback, clock mode, bit order, every length
    seed = 1;
    for (int lp = 0; lp < 2; lp++)
      for (int md = 0; md < 4; md++)
        for (int m = 0; m < 2; m++)
          for (int l = 3; l <= 16; l++) begin
            run_xfer(md >> 1, md & 1, m, (l == 16) ? 0 : l, (l == 16) ? 1 : 0, lp, seed);
            seed++;
          end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule